// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire PHY management bus as its master. Software, through a register decoder outside this block, writes one 32-bit command word. The word sets the register address, the direction, whether the preamble is sent, a divider code for the management clock, and a go bit. The block derives MDC from its own reference clock. It shifts a clause-22 frame onto MDIO through an output value and an output enable, so a pad can form the tri-state. On a read it captures the sixteen bits the PHY returns. Those bits land in the data field of the command word, which is read back on a status output.

The 5-bit PHY address comes from a static input. While a transaction runs, the busy bit of the word is set. A new command is not accepted until busy clears.

Top module: `mdio_master`

## Requirements
- R1: The command word is laid out as follows. Bits 15:0 hold the data, bits 20:16 the register address, bit 21 the direction (1 = read, 0 = write), bit 22 preamble suppression, bit 23 go and bits 26:24 the divider code. Busy reads back in bit 27, and bits 31:28 read as zero. A write that is accepted shows its fields on `cmd_rdata` in the next cycle.
- R2: A go bit that is written reads back as 1 for exactly one cycle and then clears by itself. Busy reads 1 from the cycle after that.
- R3: The MDC period in reference clocks follows the divider code: 0→4, 1→4 (reserved), 2→6, 3→8, 4→10, 5→14, 6→20, 7→28. MDC is high for half the period.
- R4: Busy stays set for exactly (frame bits × MDC period) cycles and rises only after a go.
- R5: Without suppression, a frame sends 32 ones, then 01, then the opcode (10 read, 01 write), the PHY address, the register address, a two-bit turnaround and 16 data bits, all MSB first. The whole frame is 64 MDC periods.
- R6: With suppression set, the 32 preamble ones are left out and the frame is 32 MDC periods.
- R7: On a write the master drives MDIO for every bit. The turnaround is sent as 10 and the data field is shifted out.
- R8: On a read the master releases MDIO for the turnaround and the data bits. It samples MDIO on each rising MDC edge of the data bits, and at the end the sampled value replaces the data field.
- R9: A command write that arrives while busy is set, or while a go is still pending, is ignored. No field changes.
- R10: MDIO changes only after a falling MDC edge, or when a transaction starts. While idle, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| phy_addr | input | 5 | PHY address placed in every frame |
| cmd_rdata | output | 32 | Command word read-back, including busy and read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench builds the block with its default 32-bit preamble length. Even the slowest divider code then gives a frame of under two thousand reference cycles, so every code, including the reserved one, runs as a whole transaction. A PHY model inside the bench follows the MDC edges, records each driven bit and returns a chosen word on reads. Reads and writes, with and without preamble, are checked bit for bit. Commands are also written during busy and in the go-pending cycle, and must have no effect.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int REG_LSB  = 16;
  localparam int RW_BIT   = 21;
  localparam int SUP_BIT  = 22;
  localparam int GO_BIT   = 23;
  localparam int CKS_LSB  = 24;
  localparam int BUSY_BIT = 27;
  localparam int TAIL_LEN = 32;

  // reference clocks per MDC period for a divider code
  function automatic int unsigned mdc_ratio(input logic [2:0] code);
    case (code)
      3'd2:    return 6;
      3'd3:    return 8;
      3'd4:    return 10;
      3'd5:    return 14;
      3'd6:    return 20;
      3'd7:    return 28;
      default: return 4;
    endcase
  endfunction

  // frame after the preamble: start, opcode, addresses, turnaround, data
  function automatic logic [TAIL_LEN-1:0] frame_tail(input logic rd,
                                                     input logic [ADDR_W-1:0] phy,
                                                     input logic [ADDR_W-1:0] regad,
                                                     input logic [DATA_W-1:0] data);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, regad, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       mdc,
  output logic       rise,
  output logic       fall
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             tick;

  assign lim  = CNT_W'(mdc_ratio(code) / 2 - 1);
  assign tick = run && (cnt == lim);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              rd,
  input  logic              sup,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdc_rise,
  input  logic              mdc_fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  localparam int POS_W = $clog2(PRE_LEN + TAIL_LEN);

  logic [TAIL_LEN-1:0] tail_q;
  logic                rd_q;
  logic                sup_q;
  logic [POS_W-1:0]    pos;
  logic [POS_W-1:0]    pre_n;
  logic [POS_W-1:0]    last_pos;
  logic [POS_W-1:0]    fidx;
  logic                in_pre;
  logic                in_ta;
  logic                in_data;

  assign pre_n    = sup_q ? '0 : POS_W'(PRE_LEN);
  assign last_pos = pre_n + POS_W'(TAIL_LEN - 1);
  assign fidx     = pos - pre_n;
  assign in_pre   = pos < pre_n;
  assign in_ta    = !in_pre && (fidx == POS_W'(14) || fidx == POS_W'(15));
  assign in_data  = !in_pre && (fidx >= POS_W'(16));

  assign mdio_o  = (!busy || in_pre) ? 1'b1 : tail_q[5'd31 - fidx[4:0]];
  assign mdio_oe = busy && !(rd_q && (in_ta || in_data));
  assign done    = busy && mdc_fall && (pos == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pos    <= '0;
      tail_q <= '0;
      rd_q   <= 1'b0;
      sup_q  <= 1'b0;
      rdata  <= '0;
    end else if (launch && !busy) begin
      busy   <= 1'b1;
      pos    <= '0;
      tail_q <= frame_tail(rd, phy, regad, wdata);
      rd_q   <= rd;
      sup_q  <= sup;
    end else if (busy) begin
      if (mdc_rise && rd_q && in_data)
        rdata <= {rdata[DATA_W-2:0], mdio_i};
      if (mdc_fall) begin
        if (pos == last_pos) busy <= 1'b0;
        else                 pos  <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic [ADDR_W-1:0] phy_addr,
  output logic [CMD_W-1:0]  cmd_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] reg_q;
  logic              rd_q;
  logic              sup_q;
  logic              go_q;
  logic [2:0]        cks_q;
  logic              seq_busy;
  logic              seq_done;
  logic              mdc_rise;
  logic              mdc_fall;
  logic [DATA_W-1:0] seq_rdata;
  logic              accept;
  logic              unused_hi;

  assign accept    = cmd_wr && !seq_busy && !go_q;
  assign unused_hi = ^cmd_wdata[CMD_W-1:BUSY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      reg_q  <= '0;
      rd_q   <= 1'b0;
      sup_q  <= 1'b0;
      go_q   <= 1'b0;
      cks_q  <= '0;
    end else if (accept) begin
      data_q <= cmd_wdata[DATA_W-1:0];
      reg_q  <= cmd_wdata[REG_LSB +: ADDR_W];
      rd_q   <= cmd_wdata[RW_BIT];
      sup_q  <= cmd_wdata[SUP_BIT];
      go_q   <= cmd_wdata[GO_BIT];
      cks_q  <= cmd_wdata[CKS_LSB +: 3];
    end else begin
      go_q <= 1'b0;
      if (seq_done && rd_q) data_q <= seq_rdata;
    end
  end

  assign cmd_rdata = {4'b0000, seq_busy, cks_q, go_q, sup_q, rd_q, reg_q, data_q};

  mdio_mdc_gen #(.CNT_W(5)) u_mdc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (seq_busy),
    .code (cks_q),
    .mdc  (mdc),
    .rise (mdc_rise),
    .fall (mdc_fall)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (go_q),
    .rd      (rd_q),
    .sup     (sup_q),
    .phy     (phy_addr),
    .regad   (reg_q),
    .wdata   (data_q),
    .mdc_rise(mdc_rise),
    .mdc_fall(mdc_fall),
    .mdio_i  (mdio_i),
    .busy    (seq_busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rdata   (seq_rdata),
    .done    (seq_done)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CMD_W-1:0] cmd_rdata,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy
);
  logic [5:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_len <= '0;
    else if (mdc) hi_len <= hi_len + 1'b1;
    else          hi_len <= '0;
  end

  // R2
  go_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[GO_BIT] |=> !cmd_rdata[GO_BIT]);

  // R2
  busy_follows_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[GO_BIT] |=> cmd_rdata[BUSY_BIT]);

  // R4
  busy_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_rdata[GO_BIT]));

  // R3
  mdc_high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> hi_len == 6'(mdc_ratio(cmd_rdata[CKS_LSB +: 3]) / 2));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_rdata[CKS_LSB+2:REG_LSB]));

  // R7
  write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_rdata[RW_BIT] |-> mdio_oe);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe && !mdc);

  // R10
  edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$fell(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_rdata(cmd_rdata),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .busy     (seq_busy)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [4:0]  phy_addr = 5'h0B;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit got_v [0:63];
  bit got_oe[0:63];

  always #2.5 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .phy_addr(phy_addr), .cmd_rdata(cmd_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int period_of(input logic [2:0] c);
    int t[8] = '{4, 4, 6, 8, 10, 14, 20, 28};
    return t[c];
  endfunction

  function automatic logic [31:0] pack_cmd(input bit go, input bit rd, input bit sup,
                                           input logic [2:0] cks, input logic [4:0] ra,
                                           input logic [15:0] d);
    logic [31:0] w = 32'(d);
    w = w | (32'(ra) << 16) | (32'(rd) << 21) | (32'(sup) << 22);
    w = w | (32'(go) << 23) | (32'(cks) << 24);
    return w;
  endfunction

  // expected bit i of the whole stream (preamble included)
  function automatic bit exp_bit(input int i, input bit rd, input bit sup,
                                 input logic [4:0] ra, input logic [15:0] d);
    logic [31:0] tl;
    int pre = sup ? 0 : 32;
    if (i < pre) return 1'b1;
    tl = 32'h4000_0000 | (rd ? 32'h2000_0000 : 32'h1000_0000);
    tl = tl | (32'(phy_addr) << 23) | (32'(ra) << 18) | 32'h0002_0000 | 32'(d);
    return tl[31 - (i - pre)];
  endfunction

  task automatic run_txn(input bit rd, input bit sup, input logic [2:0] cks,
                         input logic [4:0] ra, input logic [15:0] d,
                         input logic [15:0] resp, input bit poke);
    int nbits = sup ? 32 : 64;
    int pre = sup ? 0 : 32;
    int per = period_of(cks);
    int nb = 0, n = 0, hi_run = 0, first_hi = 0, it = 0, bad = 0;
    bit prev = 1'b0;
    @(negedge clk);
    cmd_wdata = pack_cmd(1'b1, rd, sup, cks, ra, d);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata[23] == 1'b1 && cmd_rdata[27] == 1'b0, "R2 go visible", cmd_rdata, 32'h0080_0000);
    check(cmd_rdata[26:0] == pack_cmd(1'b1, rd, sup, cks, ra, d)[26:0], "R1 fields", cmd_rdata, pack_cmd(1'b1, rd, sup, cks, ra, d));
    @(negedge clk);
    check(cmd_rdata[23] == 1'b0 && cmd_rdata[27] == 1'b1, "R2 go cleared, busy", cmd_rdata, 32'h0800_0000);
    mdio_i = 1'b1;
    while (cmd_rdata[27] && it < 4000) begin
      nb++;
      if (mdc && !prev && n < 64) begin
        got_v[n] = mdio_o;
        got_oe[n] = mdio_oe;
        n++;
      end
      if (!mdc && prev) begin
        if (first_hi == 0) first_hi = hi_run;
        if (n - pre - 16 >= 0 && n - pre - 16 < 16) mdio_i = resp[15 - (n - pre - 16)];
        else mdio_i = 1'b1;
      end
      hi_run = mdc ? hi_run + 1 : 0;
      if (poke && it == 3) begin
        cmd_wdata = pack_cmd(1'b1, !rd, !sup, cks ^ 3'd5, ~ra, ~d);
        cmd_wr = 1'b1;
      end else cmd_wr = 1'b0;
      prev = mdc;
      it++;
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    check(nb == nbits * per, "R4 busy length", nb, nbits * per);
    check(first_hi == per / 2, "R3 mdc high half", first_hi, per / 2);
    check(n == nbits, sup ? "R6 frame bit count" : "R5 frame bit count", n, nbits);
    for (int i = 0; i < n; i++) begin
      bit eoe = !(rd && i >= pre + 14);
      if (got_oe[i] != eoe) bad++;
      else if (eoe && got_v[i] != exp_bit(i, rd, sup, ra, d)) bad++;
    end
    check(bad == 0, rd ? "R8 read frame" : (sup ? "R6 write frame" : "R7 R5 write frame"), bad, 0);
    check(cmd_rdata == pack_cmd(1'b0, rd, sup, cks, ra, rd ? resp : d),
          rd ? "R8 read data captured" : (poke ? "R9 poke ignored" : "R7 data kept"),
          cmd_rdata, pack_cmd(1'b0, rd, sup, cks, ra, rd ? resp : d));
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle after done", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_rdata == 32'h0, "R1 reset word", cmd_rdata, 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 reset idle", {mdc, mdio_oe}, 0);

    // R1: write without go only loads fields
    cmd_wdata = pack_cmd(1'b0, 1'b1, 1'b0, 3'd3, 5'h12, 16'hBEEF);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd_rdata == pack_cmd(1'b0, 1'b1, 1'b0, 3'd3, 5'h12, 16'hBEEF), "R1 load no go",
          cmd_rdata, pack_cmd(1'b0, 1'b1, 1'b0, 3'd3, 5'h12, 16'hBEEF));
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 no go stays idle", {mdc, mdio_oe}, 0);

    // every divider code, R3 including reserved code 1
    for (int c = 0; c < 8; c++)
      run_txn(c[0], c[1], 3'(c), 5'(c * 3), 16'(16'h1234 * (c + 1)), 16'(16'hA5C3 ^ c), 1'b0);

    // directed corners
    run_txn(1'b1, 1'b1, 3'd0, 5'h1F, 16'h0000, 16'hFFFF, 1'b0);
    run_txn(1'b1, 1'b0, 3'd0, 5'h00, 16'hFFFF, 16'h0001, 1'b0);
    run_txn(1'b0, 1'b0, 3'd2, 5'h15, 16'h8001, 16'h0000, 1'b1);
    run_txn(1'b1, 1'b1, 3'd4, 5'h0A, 16'h5555, 16'h8000, 1'b1);

    // R9: second write in the go-pending cycle is ignored
    @(negedge clk);
    cmd_wdata = pack_cmd(1'b1, 1'b0, 1'b1, 3'd0, 5'h03, 16'h0F0F);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wdata = pack_cmd(1'b1, 1'b1, 1'b0, 3'd7, 5'h1C, 16'hF0F0);
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata == (pack_cmd(1'b0, 1'b0, 1'b1, 3'd0, 5'h03, 16'h0F0F) | 32'h0800_0000),
          "R9 pending write ignored", cmd_rdata,
          pack_cmd(1'b0, 1'b0, 1'b1, 3'd0, 5'h03, 16'h0F0F) | 32'h0800_0000);
    repeat (200) @(negedge clk);
    check(cmd_rdata == pack_cmd(1'b0, 1'b0, 1'b1, 3'd0, 5'h03, 16'h0F0F),
          "R9 R4 pending ignored after done", cmd_rdata,
          pack_cmd(1'b0, 1'b0, 1'b1, 3'd0, 5'h03, 16'h0F0F));

    // constrained random mix
    for (int k = 0; k < 16; k++) begin
      logic [31:0] r = $urandom;
      logic [31:0] q = $urandom;
      phy_addr = r[30:26];
      run_txn(r[0], r[1], 3'(r[4:2] & 3'd5), r[9:5], q[15:0], q[31:16], r[10]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule